// File: doc/BRIEF.md
# Analog Pin Boundary Switch Controller

This block is the digital control cell that sits behind one analog pin in a mixed-signal boundary-scan chain. A test access port controller outside the block supplies the test clock, an active-low asynchronous test reset, and the capture, shift and update strobes. It also supplies a decoded two-bit instruction mode. A comparator outside the block reports whether the pin voltage is above a threshold, and the cell samples that one-bit result during capture.

The cell has a four-bit scan register clocked on the rising test clock edge and a four-bit control register loaded on the falling edge. The control bits are a drive data bit, a core-isolate bit, a stimulus-bus enable and a measure-bus enable. Together with the mode, they decode into six switch enables: core connect, drive-high, drive-low, ground return, stimulus bus and measure bus. Fixed exclusion rules apply. At most one of high, low and ground is on, and none of them is on while the core is connected. The analog switches themselves are outside the block.

Top module: `abm_switch_ctrl`

## Requirements
- R1: While rst_ni is low, both the control register and the scan register are cleared to 0, so scan_o is 0. The cell then behaves as a cell whose control register holds 0.
- R2: When shift_en_i is high and capture_en_i is low at a rising tck_i edge, the scan register moves one place toward bit 0 and scan_i enters bit 3. scan_o always shows bit 0, so a bit appears at scan_o four shifts after it enters.
- R3: When capture_en_i is high at a rising tck_i edge, scan bit 0 takes cmp_i. Scan bits 3..1 take control register bits 3..1. Capture takes priority over shift.
- R4: The control register loads the whole scan register on a falling tck_i edge when update_en_i is high, and holds otherwise. Shifting or capturing alone leaves every switch output unchanged. Control bits: bit 0 is drive data, bit 1 is core isolate, bit 2 is stimulus bus enable, bit 3 is measure bus enable.
- R5: With mode_i = 0 (mission) or mode_i = 1 (sample), sw_core_o is 1 and the other five switch outputs are 0, whatever the control register holds.
- R6: With mode_i = 2 (extest), sw_core_o is 0. sw_high_o equals the data bit and sw_low_o is its inverse. sw_gnd_o, sw_bus1_o and sw_bus2_o are 0.
- R7: With mode_i = 3 (probe), sw_core_o is the inverse of the isolate bit, and sw_bus1_o and sw_bus2_o follow their enable bits. sw_gnd_o is 1 only when isolate and data are 1 and the stimulus bus is off. sw_high_o and sw_low_o are 0.
- R8: At most one of sw_high_o, sw_low_o and sw_gnd_o is 1 at any time, and any of them being 1 implies sw_core_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous test reset, active low |
| mode_i | input | 2 | Decoded mode: 0 mission, 1 sample, 2 extest, 3 probe |
| capture_en_i | input | 1 | Capture strobe |
| shift_en_i | input | 1 | Shift strobe |
| update_en_i | input | 1 | Update strobe |
| scan_i | input | 1 | Serial scan input |
| cmp_i | input | 1 | Comparator result for the pin level |
| scan_o | output | 1 | Serial scan output |
| sw_core_o | output | 1 | Core connect switch closed |
| sw_high_o | output | 1 | Drive-high switch closed |
| sw_low_o | output | 1 | Drive-low switch closed |
| sw_gnd_o | output | 1 | Ground return switch closed |
| sw_bus1_o | output | 1 | Stimulus bus switch closed |
| sw_bus2_o | output | 1 | Measure bus switch closed |

## Verification
The bench builds the cell with its only configuration: a four-bit control word and a two-bit mode. All 16 control words are loaded through the scan path and committed, and each one is checked under all four modes. That covers every combination of the switch decode, including the exclusion corner where the ground return yields to the stimulus bus. Scan-out order, capture readback for both comparator levels, update holding during shifts, and an asynchronous reset in the middle of a run are each checked at the pins.

// File: rtl/abm_pkg.sv
package abm_pkg;
  localparam int unsigned CTRL_W = 4;
  localparam int unsigned MODE_W = 2;
  localparam int unsigned SW_W   = 6;

  localparam int unsigned B_DATA = 0;
  localparam int unsigned B_ISO  = 1;
  localparam int unsigned B_BUS1 = 2;
  localparam int unsigned B_BUS2 = 3;

  typedef enum logic [MODE_W-1:0] {
    M_MISSION = 2'd0,
    M_SAMPLE  = 2'd1,
    M_EXTEST  = 2'd2,
    M_PROBE   = 2'd3
  } abm_mode_e;

  typedef struct packed {
    logic core;
    logic high;
    logic low;
    logic gnd;
    logic bus1;
    logic bus2;
  } abm_sw_t;
endpackage

// File: rtl/abm_scan_stage.sv
module abm_scan_stage #(
  parameter int unsigned W = abm_pkg::CTRL_W
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic         capture_en_i,
  input  logic         shift_en_i,
  input  logic         scan_i,
  input  logic         cmp_i,
  input  logic [W-1:0] ctrl_i,
  output logic [W-1:0] sr_o
);
  logic [W-1:0] sr_q, sr_d;

  // bit 0 captures the comparator, upper bits read back the control word
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic cap_v, sh_v;
    if (i == 0) begin : g_lsb
      assign cap_v = cmp_i;
    end else begin : g_up
      assign cap_v = ctrl_i[i];
    end
    if (i == W-1) begin : g_msb
      assign sh_v = scan_i;
    end else begin : g_mid
      assign sh_v = sr_q[i+1];
    end
    always_comb begin
      if (capture_en_i)    sr_d[i] = cap_v;
      else if (shift_en_i) sr_d[i] = sh_v;
      else                 sr_d[i] = sr_q[i];
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/abm_update_reg.sv
module abm_update_reg #(
  parameter int unsigned W = abm_pkg::CTRL_W
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic         update_en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)          q_o <= '0;
    else if (update_en_i) q_o <= d_i;
  end
endmodule

// File: rtl/abm_switch_decode.sv
module abm_switch_decode
  import abm_pkg::*;
(
  input  abm_mode_e           mode_i,
  input  logic [CTRL_W-1:0]   ctrl_i,
  output abm_sw_t             sw_o
);
  logic data, iso, b1, b2;
  assign data = ctrl_i[B_DATA];
  assign iso  = ctrl_i[B_ISO];
  assign b1   = ctrl_i[B_BUS1];
  assign b2   = ctrl_i[B_BUS2];

  always_comb begin
    sw_o      = '0;
    sw_o.core = 1'b1;
    unique case (mode_i)
      M_EXTEST: begin
        sw_o.core = 1'b0;
        sw_o.high = data;
        sw_o.low  = ~data;
      end
      M_PROBE: begin
        sw_o.core = ~iso;
        sw_o.bus1 = b1;
        sw_o.bus2 = b2;
        // ground return only with core isolated and no stimulus on bus 1
        sw_o.gnd  = iso & data & ~b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/abm_switch_ctrl.sv
module abm_switch_ctrl
  import abm_pkg::*;
(
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              capture_en_i,
  input  logic              shift_en_i,
  input  logic              update_en_i,
  input  logic              scan_i,
  input  logic              cmp_i,
  output logic              scan_o,
  output logic              sw_core_o,
  output logic              sw_high_o,
  output logic              sw_low_o,
  output logic              sw_gnd_o,
  output logic              sw_bus1_o,
  output logic              sw_bus2_o
);
  logic [CTRL_W-1:0] sr, upd;
  abm_sw_t           sw;

  abm_scan_stage #(.W(CTRL_W)) u_scan (
    .tck_i       (tck_i),
    .rst_ni      (rst_ni),
    .capture_en_i(capture_en_i),
    .shift_en_i  (shift_en_i),
    .scan_i      (scan_i),
    .cmp_i       (cmp_i),
    .ctrl_i      (upd),
    .sr_o        (sr)
  );

  abm_update_reg #(.W(CTRL_W)) u_upd (
    .tck_i      (tck_i),
    .rst_ni     (rst_ni),
    .update_en_i(update_en_i),
    .d_i        (sr),
    .q_o        (upd)
  );

  abm_switch_decode u_dec (
    .mode_i(abm_mode_e'(mode_i)),
    .ctrl_i(upd),
    .sw_o  (sw)
  );

  assign scan_o    = sr[0];
  assign sw_core_o = sw.core;
  assign sw_high_o = sw.high;
  assign sw_low_o  = sw.low;
  assign sw_gnd_o  = sw.gnd;
  assign sw_bus1_o = sw.bus1;
  assign sw_bus2_o = sw.bus2;
endmodule

// File: rtl/abm_switch_ctrl_chk.sv
module abm_switch_ctrl_chk (
  input logic       tck_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       capture_en_i,
  input logic       shift_en_i,
  input logic       cmp_i,
  input logic       scan_o,
  input logic [3:0] sr,
  input logic [3:0] upd,
  input logic       sw_core_o,
  input logic       sw_high_o,
  input logic       sw_low_o,
  input logic       sw_gnd_o,
  input logic       sw_bus1_o,
  input logic       sw_bus2_o
);
  // R8
  drive_excl_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0({sw_high_o, sw_low_o, sw_gnd_o}));
  // R8
  drive_iso_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (sw_high_o | sw_low_o | sw_gnd_o) |-> !sw_core_o);
  // R5
  mission_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (mode_i[1] == 1'b0) |-> (sw_core_o && !sw_high_o && !sw_low_o && !sw_gnd_o
                             && !sw_bus1_o && !sw_bus2_o));
  // R2
  shift_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_en_i && !capture_en_i) |=> (scan_o == $past(sr[1])));
  // R3
  capture_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_en_i |=> (scan_o == $past(cmp_i)));
  // R7
  probe_bus_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (mode_i == 2'd3) |-> (sw_bus1_o == upd[2] && sw_bus2_o == upd[3]));
endmodule

bind abm_switch_ctrl abm_switch_ctrl_chk u_chk (
  .tck_i       (tck_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .capture_en_i(capture_en_i),
  .shift_en_i  (shift_en_i),
  .cmp_i       (cmp_i),
  .scan_o      (scan_o),
  .sr          (sr),
  .upd         (upd),
  .sw_core_o   (sw_core_o),
  .sw_high_o   (sw_high_o),
  .sw_low_o    (sw_low_o),
  .sw_gnd_o    (sw_gnd_o),
  .sw_bus1_o   (sw_bus1_o),
  .sw_bus2_o   (sw_bus2_o)
);

// File: tb/abm_switch_ctrl_bench.sv
module abm_switch_ctrl_bench;
  logic       tck_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic       capture_en_i = 1'b0, shift_en_i = 1'b0, update_en_i = 1'b0;
  logic       scan_i = 1'b0, cmp_i = 1'b0;
  logic       scan_o, sw_core_o, sw_high_o, sw_low_o, sw_gnd_o, sw_bus1_o, sw_bus2_o;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #10 tck_i = ~tck_i;

  abm_switch_ctrl u_abm_switch_ctrl (.*);

  function automatic logic [5:0] expect_sw(input logic [1:0] m, input logic [3:0] u);
    // order: core high low gnd bus1 bus2
    case (m)
      2'd2:    return {1'b0, u[0], ~u[0], 3'b000};
      2'd3:    return {~u[1], 2'b00, u[1] & u[0] & ~u[2], u[2], u[3]};
      default: return 6'b100000;
    endcase
  endfunction

  function automatic logic [5:0] got_sw();
    return {sw_core_o, sw_high_o, sw_low_o, sw_gnd_o, sw_bus1_o, sw_bus2_o};
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge tck_i);
    #2;
  endtask

  task automatic load(input logic [3:0] v);
    shift_en_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      scan_i = v[i];
      step();
    end
    shift_en_i = 1'b0;
    scan_i = 1'b0;
  endtask

  task automatic commit();
    update_en_i = 1'b1;
    step();
    update_en_i = 1'b0;
  endtask

  task automatic check_modes(input logic [3:0] u, input string req);
    for (int m = 0; m < 4; m++) begin
      mode_i = 2'(m);
      #1;
      check(req, got_sw(), expect_sw(2'(m), u));
    end
  endtask

  initial begin
    repeat (2000) @(posedge tck_i);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0] obs;
    step();
    // R1 reset state
    mode_i = 2'd3;
    #1;
    check("R1 reset probe", got_sw(), 6'b100000);
    check("R1 reset scan_o", {5'b0, scan_o}, 6'b0);
    rst_ni = 1'b1;
    step();

    // R5 R6 R7 sweep over every control word and mode
    for (int u = 0; u < 16; u++) begin
      load(4'(u));
      commit();
      check_modes(4'(u), "R5/R6/R7 sweep");
    end

    // R2 scan-out order
    load(4'b1101);
    obs = '0;
    shift_en_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      obs[i] = scan_o;
      step();
    end
    shift_en_i = 1'b0;
    check("R2 scan order", {2'b0, obs}, 6'b001101);

    // R4 shifting without update leaves outputs alone
    load(4'b0011);
    commit();
    mode_i = 2'd3;
    #1;
    check("R4 committed", got_sw(), expect_sw(2'd3, 4'b0011));
    load(4'b1100);
    check("R4 hold after shift", got_sw(), expect_sw(2'd3, 4'b0011));
    commit();
    check("R4 after update", got_sw(), expect_sw(2'd3, 4'b1100));

    // R3 capture readback for both comparator levels
    for (int c = 0; c < 2; c++) begin
      load(4'b1010);
      commit();
      cmp_i = 1'(c);
      capture_en_i = 1'b1;
      shift_en_i = 1'b1;   // capture wins over shift
      step();
      capture_en_i = 1'b0;
      check("R3 hold outputs", got_sw(), expect_sw(2'd3, 4'b1010));
      for (int i = 0; i < 4; i++) begin
        obs[i] = scan_o;
        step();
      end
      shift_en_i = 1'b0;
      check("R3 capture", {2'b0, obs}, {2'b0, 3'b101, 1'(c)});
    end

    // R8 exclusion walk in extest and probe
    for (int u = 0; u < 16; u++) begin
      load(4'(u));
      commit();
      for (int m = 2; m < 4; m++) begin
        mode_i = 2'(m);
        #1;
        check("R8 exclusion",
              {5'b0, ($countones({sw_high_o, sw_low_o, sw_gnd_o}) <= 1)
                     && !((sw_high_o | sw_low_o | sw_gnd_o) && sw_core_o)},
              6'b000001);
      end
    end

    // R1 asynchronous reset mid-run
    load(4'b1111);
    commit();
    mode_i = 2'd3;
    #3;
    rst_ni = 1'b0;
    #1;
    check("R1 async clear", got_sw(), 6'b100000);
    check("R1 async scan", {5'b0, scan_o}, 6'b0);
    step();
    rst_ni = 1'b1;
    step();
    capture_en_i = 1'b1;
    cmp_i = 1'b0;
    step();
    capture_en_i = 1'b0;
    shift_en_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      obs[i] = scan_o;
      step();
    end
    shift_en_i = 1'b0;
    check("R1 readback zero", {2'b0, obs}, 6'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule